// File: doc/BRIEF.md
# Operating-Mode and Reset Sequencer

This block decides which operating mode a power-management device is in and drives its active-low reset line to the host controller. There are four modes: Active, Flash (watchdog off, entered by a high programming level), V1-standby (the logic supply stays up) and battery-standby (everything off except the wake logic). Its inputs are already digital: a request strobe carrying two standby bits, a wake-up event tagged with the source it came from, a raw undervoltage comparator on the logic supply, a supply power-good flag, the flash-entry level, a thermal-shutdown flag and a one-cycle watchdog-failure pulse. All timing comes from a free-running one-microsecond tick input.

Reset is stretched by a single release counter. Every reset cause clears the counter, and the reset line stays low until the counter has seen a full hold time of clean ticks. A wake-up that leaves V1-standby is sorted by its source and by the interrupt-enable bit. The result is one of three things: a reset pulse, a reset-free wake that opens a window in which watchdog failures are masked, or an interrupt pulse. The undervoltage comparator is filtered, so that only a dip longer than the filter time pulls reset low. A supply that is still not good a fixed time after turn-on is treated as a short, and the block drops to battery-standby.

Top module: `pwr_seq_top`

## Requirements
- R1: After a synchronous reset, `mode` is 0 (Active), `nreset` is 0, and `irq_out` and `rst_block` are 0. `nreset` rises only after `v1_good` has been high, with no other reset cause, for RST_HOLD_US ticks. Any reset cause clears that count.
- R2: If `v1_uv` stays high for UV_FILT_US ticks or fewer, `nreset` is unchanged. If it stays high for more than UV_FILT_US ticks, `nreset` goes low and is released RST_HOLD_US ticks after `v1_uv` clears.
- R3: A `cmd_wr` strobe in Active with only `cmd_v1sb` set selects mode 2 (V1-standby) and keeps `nreset` high. If `cmd_batsb` is set, alone or together with `cmd_v1sb`, the strobe selects mode 3 (battery-standby). In mode 3, `nreset` is low.
- R4: Any wake event (`wake_vld`) in mode 3 returns the device to mode 0. `nreset` is released RST_HOLD_US ticks later.
- R5: With `irq_en` = 0, a wake from mode 2 whose `wake_src` is 3 (contact input) or 4 (open load) returns the device to mode 0 and pulls `nreset` low for RST_HOLD_US ticks.
- R6: With `irq_en` = 0, a wake from mode 2 whose `wake_src` is 0 (LIN), 1 (INH) or 2 (SPI) returns the device to mode 0 without a reset. It also raises `rst_block` for BLOCK_US ticks. A `wd_fail` pulse while `rst_block` is high has no effect on `nreset`.
- R7: With `irq_en` = 1, any wake from mode 2 returns the device to mode 0 with `nreset` kept high and `irq_out` high for IRQ_US ticks.
- R8: In mode 0, `flash_lvl` = 1 selects mode 1 (Flash). In mode 1, `wd_fail` is ignored. When `flash_lvl` falls, the device returns to mode 0 with a reset pulse of RST_HOLD_US ticks.
- R9: If `v1_good` is still low SHORT_US ticks after turn-on (power-on reset, or a wake out of mode 3), the mode becomes 3.
- R10: `tsd` = 1 in modes 0, 1 or 2 selects mode 3.
- R11: In modes 0 and 1, `wake_vld` is ignored: the mode and `nreset` do not change.
- R12: A `wd_fail` pulse in mode 0 or 2 while `rst_block` is low pulls `nreset` low for RST_HOLD_US ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| cmd_wr | input | 1 | Standby request strobe |
| cmd_v1sb | input | 1 | Request V1-standby (valid with `cmd_wr`) |
| cmd_batsb | input | 1 | Request battery-standby (valid with `cmd_wr`, dominant) |
| wake_vld | input | 1 | Wake-up event pulse |
| wake_src | input | 3 | Wake source: 0 LIN, 1 INH, 2 SPI, 3 contact input, 4 open load |
| irq_en | input | 1 | Wakes from V1-standby signal by interrupt instead of reset |
| v1_uv | input | 1 | Raw logic-supply undervoltage comparator |
| v1_good | input | 1 | Logic supply above its fail threshold |
| flash_lvl | input | 1 | Flash-entry level detected |
| tsd | input | 1 | Thermal-shutdown flag |
| wd_fail | input | 1 | Watchdog failure pulse |
| mode | output | 2 | 0 Active, 1 Flash, 2 V1-standby, 3 battery-standby |
| nreset | output | 1 | Active-low reset to the host |
| irq_out | output | 1 | Wake interrupt pulse |
| rst_block | output | 1 | Window in which watchdog failures are masked |

## Verification
The bench aims at the two lengths of an undervoltage dip that sit on either side of the filter threshold. A design whose filter compares with the wrong sign, or that resets on any dip, shows reset dropping on the short dip. The bench sends each wake-source class out of V1-standby, with the interrupt enable both clear and set. A misclassified source shows up as a reset where none belongs, or as a missing masking window. The bench fires a watchdog failure inside the masking window and again after it, and once more in Flash mode, so that a design that ignores the window or the mode would reset. It also writes both standby bits together, to catch a priority swap that would leave reset high in V1-standby. It holds the supply not-good through the short-detect time, so that a design missing the turn-on check stays in Active.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [1:0] {
      MODE_ACTIVE = 2'd0,
      MODE_FLASH  = 2'd1,
      MODE_V1SB   = 2'd2,
      MODE_BATSB  = 2'd3
   } mode_e;

   localparam int unsigned SRC_W = 3;

   // Sources 0..2 (LIN, INH, SPI) leave V1-standby without a reset
   function automatic logic src_is_quiet(input logic [SRC_W-1:0] src);
      return (src <= 3'd2);
   endfunction

endpackage

// File: rtl/pwr_seq_uvflt.sv
module pwr_seq_uvflt #(
   parameter int unsigned LIMIT_US = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic uv_in,
   output logic uv_flt
);

   generate
      if (LIMIT_US == 0) begin : g_pass
         assign uv_flt = uv_in;
      end else begin : g_cnt
         localparam int unsigned W = $clog2(LIMIT_US + 2);
         localparam logic [W-1:0] TOP = W'(LIMIT_US + 1);
         logic [W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst || !uv_in)
               cnt_q <= '0;
            else if (tick && cnt_q != TOP)
               cnt_q <= cnt_q + 1'b1;
         end

         assign uv_flt = (cnt_q == TOP);

         // Clearing the comparator drops the filtered flag one cycle later
         assert_uv_release_R2: assert property (@(posedge clk) disable iff (rst)
            !uv_in |=> !uv_flt);
      end
   endgenerate

endmodule

// File: rtl/pwr_seq_window.sv
module pwr_seq_window #(
   parameter int unsigned LEN_US = 2000
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic start,
   output logic active
);

   generate
      if (LEN_US == 0) begin : g_off
         assign active = 1'b0;
      end else begin : g_on
         localparam int unsigned W = $clog2(LEN_US + 1);
         localparam logic [W-1:0] LIM = W'(LEN_US);
         logic [W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst)
               cnt_q <= '0;
            else if (start)
               cnt_q <= LIM;
            else if (tick && cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end

         assign active = (cnt_q != '0);

         assert_window_opens_R6: assert property (@(posedge clk) disable iff (rst)
            start |=> active);
      end
   endgenerate

endmodule

// File: rtl/pwr_seq_rstgen.sv
module pwr_seq_rstgen #(
   parameter int unsigned HOLD_US = 2000
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic kill,
   output logic nreset
);

   localparam int unsigned W = $clog2(HOLD_US + 1);
   localparam logic [W-1:0] LIM = W'(HOLD_US);

   if (HOLD_US < 1) begin : g_bad_hold
      $error("pwr_seq_rstgen: HOLD_US must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || kill)
         cnt_q <= '0;
      else if (tick && cnt_q != LIM)
         cnt_q <= cnt_q + 1'b1;
   end

   assign nreset = (cnt_q == LIM);

   assert_kill_low_R1: assert property (@(posedge clk) disable iff (rst)
      kill |=> !nreset);

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
   import pwr_seq_pkg::*;
#(
   parameter int unsigned RST_HOLD_US = 2000,
   parameter int unsigned UV_FILT_US  = 8,
   parameter int unsigned SHORT_US    = 4000,
   parameter int unsigned BLOCK_US    = 2000,
   parameter int unsigned IRQ_US      = 2000
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_us,
   input  logic             cmd_wr,
   input  logic             cmd_v1sb,
   input  logic             cmd_batsb,
   input  logic             wake_vld,
   input  logic [SRC_W-1:0] wake_src,
   input  logic             irq_en,
   input  logic             v1_uv,
   input  logic             v1_good,
   input  logic             flash_lvl,
   input  logic             tsd,
   input  logic             wd_fail,
   output logic [1:0]       mode,
   output logic             nreset,
   output logic             irq_out,
   output logic             rst_block
);

   localparam int unsigned SC_W = $clog2(SHORT_US + 1);
   localparam logic [SC_W-1:0] SC_LIM = SC_W'(SHORT_US);

   if (SHORT_US < 1) begin : g_bad_short
      $error("pwr_seq_top: SHORT_US must be at least 1");
   end

   mode_e           mode_q, mode_d;
   logic            sc_run_q;
   logic [SC_W-1:0] sc_cnt_q;
   logic            uv_flt, short_hit;
   logic            from_v1, quiet, irq_start, blk_start, wake_rst;
   logic            flash_exit, wd_rst, kill;

   // ---- wake classification ----
   assign from_v1   = wake_vld && (mode_q == MODE_V1SB);
   assign quiet     = src_is_quiet(wake_src);
   assign irq_start = from_v1 && irq_en;
   assign blk_start = from_v1 && !irq_en && quiet;
   assign wake_rst  = from_v1 && !irq_en && !quiet;

   assign flash_exit = (mode_q == MODE_FLASH) && !flash_lvl;
   assign wd_rst     = wd_fail && !rst_block &&
                       (mode_q == MODE_ACTIVE || mode_q == MODE_V1SB);
   assign short_hit  = sc_run_q && (sc_cnt_q == SC_LIM) && !v1_good &&
                       (mode_q == MODE_ACTIVE || mode_q == MODE_FLASH);

   assign kill = wake_rst || flash_exit || wd_rst || !v1_good || uv_flt ||
                 (mode_q == MODE_BATSB);

   // ---- mode state machine ----
   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_ACTIVE: begin
            if (tsd || short_hit)             mode_d = MODE_BATSB;
            else if (cmd_wr && cmd_batsb)     mode_d = MODE_BATSB;
            else if (cmd_wr && cmd_v1sb)      mode_d = MODE_V1SB;
            else if (flash_lvl)               mode_d = MODE_FLASH;
         end
         MODE_FLASH: begin
            if (tsd || short_hit)             mode_d = MODE_BATSB;
            else if (!flash_lvl)              mode_d = MODE_ACTIVE;
         end
         MODE_V1SB: begin
            if (tsd)                          mode_d = MODE_BATSB;
            else if (wake_vld)                mode_d = MODE_ACTIVE;
         end
         MODE_BATSB: begin
            if (wake_vld)                     mode_d = MODE_ACTIVE;
         end
         default:                             mode_d = MODE_ACTIVE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) mode_q <= MODE_ACTIVE;
      else     mode_q <= mode_d;
   end

   // ---- supply short check after turn-on ----
   always_ff @(posedge clk) begin
      if (rst) begin
         sc_run_q <= 1'b1;
         sc_cnt_q <= '0;
      end else if (mode_q == MODE_BATSB && mode_d == MODE_ACTIVE) begin
         sc_run_q <= 1'b1;
         sc_cnt_q <= '0;
      end else if (mode_d == MODE_BATSB) begin
         sc_run_q <= 1'b0;
      end else if (sc_run_q) begin
         if (sc_cnt_q == SC_LIM)  sc_run_q <= 1'b0;
         else if (tick_us)        sc_cnt_q <= sc_cnt_q + 1'b1;
      end
   end

   // ---- sub-blocks ----
   pwr_seq_uvflt #(.LIMIT_US(UV_FILT_US)) uvflt_i (
      .clk(clk), .rst(rst), .tick(tick_us), .uv_in(v1_uv), .uv_flt(uv_flt));

   pwr_seq_rstgen #(.HOLD_US(RST_HOLD_US)) rstgen_i (
      .clk(clk), .rst(rst), .tick(tick_us), .kill(kill), .nreset(nreset));

   pwr_seq_window #(.LEN_US(BLOCK_US)) blk_win_i (
      .clk(clk), .rst(rst), .tick(tick_us), .start(blk_start), .active(rst_block));

   pwr_seq_window #(.LEN_US(IRQ_US)) irq_win_i (
      .clk(clk), .rst(rst), .tick(tick_us), .start(irq_start), .active(irq_out));

   assign mode = mode_q;

   // ---- assertions ----
   assert_batsb_low_R3: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_BATSB) |=> !nreset);

   assert_wake_returns_R4: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_BATSB && wake_vld) |=> (mode_q == MODE_ACTIVE));

   assert_v1sb_exit_R5: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_V1SB) |=> (mode_q != MODE_FLASH));

   assert_flash_exit_rst_R8: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_FLASH && !flash_lvl) |=> !nreset);

   assert_short_batsb_R9: assert property (@(posedge clk) disable iff (rst)
      short_hit |=> (mode_q == MODE_BATSB));

endmodule

// File: tb/pwr_seq_top_tb_top.sv
module pwr_seq_top_tb_top;

   localparam int unsigned T_HOLD  = 16;
   localparam int unsigned T_UVF   = 8;
   localparam int unsigned T_SHORT = 40;
   localparam int unsigned T_BLK   = 16;
   localparam int unsigned T_IRQ   = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick_us = 1'b0;
   logic cmd_wr = 1'b0, cmd_v1sb = 1'b0, cmd_batsb = 1'b0;
   logic wake_vld = 1'b0;
   logic [2:0] wake_src = 3'd0;
   logic irq_en = 1'b0, v1_uv = 1'b0, v1_good = 1'b1;
   logic flash_lvl = 1'b0, tsd = 1'b0, wd_fail = 1'b0;
   logic [1:0] mode;
   logic nreset, irq_out, rst_block;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   int unsigned div = 0;
   always @(negedge clk) begin
      div <= (div == 3) ? 0 : div + 1;
      tick_us <= (div == 3);
   end

   pwr_seq_top #(
      .RST_HOLD_US(T_HOLD), .UV_FILT_US(T_UVF), .SHORT_US(T_SHORT),
      .BLOCK_US(T_BLK), .IRQ_US(T_IRQ)
   ) dut_i (
      .clk(clk), .rst(rst), .tick_us(tick_us),
      .cmd_wr(cmd_wr), .cmd_v1sb(cmd_v1sb), .cmd_batsb(cmd_batsb),
      .wake_vld(wake_vld), .wake_src(wake_src), .irq_en(irq_en),
      .v1_uv(v1_uv), .v1_good(v1_good), .flash_lvl(flash_lvl),
      .tsd(tsd), .wd_fail(wd_fail),
      .mode(mode), .nreset(nreset), .irq_out(irq_out), .rst_block(rst_block));

   // ---- scoreboard ----
   typedef struct packed {
      logic [1:0] mode;
      logic       nrst;
      logic       irq;
      logic       blk;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   task automatic expect_state(input string tag, input logic [1:0] m,
                               input logic n, input logic i, input logic b);
      exp_q.push_back('{mode: m, nrst: n, irq: i, blk: b});
      tag_q.push_back(tag);
   endtask

   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         exp_t  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_run++;
         if (mode !== e.mode || nreset !== e.nrst || irq_out !== e.irq ||
             rst_block !== e.blk) begin
            n_fail++;
            $display("FAIL %s: actual mode=%0d nreset=%b irq=%b blk=%b expected mode=%0d nreset=%b irq=%b blk=%b",
                     t, mode, nreset, irq_out, rst_block, e.mode, e.nrst, e.irq, e.blk);
         end
      end
   end

   // ---- driver helpers ----
   task automatic wait_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         do @(posedge clk); while (!tick_us);
      end
      #1;
   endtask

   task automatic pulse_wake(input logic [2:0] src);
      wake_src = src; wake_vld = 1'b1;
      @(posedge clk); #1 wake_vld = 1'b0;
   endtask

   task automatic pulse_wd();
      wd_fail = 1'b1;
      @(posedge clk); #1 wd_fail = 1'b0;
   endtask

   task automatic request(input logic v1, input logic bat);
      cmd_v1sb = v1; cmd_batsb = bat; cmd_wr = 1'b1;
      @(posedge clk); #1 cmd_wr = 1'b0; cmd_v1sb = 1'b0; cmd_batsb = 1'b0;
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 rst = 1'b0;
      @(posedge clk); #1;
      expect_state("R1 reset state", 2'd0, 1'b0, 1'b0, 1'b0);
      wait_ticks(10);
      expect_state("R1 reset still held", 2'd0, 1'b0, 1'b0, 1'b0);
      wait_ticks(10);
      expect_state("R1 reset released", 2'd0, 1'b1, 1'b0, 1'b0);

      // R11: wake in Active is ignored
      pulse_wake(3'd3);
      wait_ticks(2);
      expect_state("R11 wake ignored in active", 2'd0, 1'b1, 1'b0, 1'b0);

      // R2: dip at the filter limit, then a longer one
      v1_uv = 1'b1; wait_ticks(T_UVF); v1_uv = 1'b0;
      wait_ticks(1);
      expect_state("R2 short dip filtered", 2'd0, 1'b1, 1'b0, 1'b0);
      v1_uv = 1'b1; wait_ticks(12);
      expect_state("R2 long dip resets", 2'd0, 1'b0, 1'b0, 1'b0);
      v1_uv = 1'b0; wait_ticks(10);
      expect_state("R2 hold after dip", 2'd0, 1'b0, 1'b0, 1'b0);
      wait_ticks(10);
      expect_state("R2 release after dip", 2'd0, 1'b1, 1'b0, 1'b0);

      // R12: watchdog failure in Active
      pulse_wd(); wait_ticks(2);
      expect_state("R12 wd reset", 2'd0, 1'b0, 1'b0, 1'b0);
      wait_ticks(20);
      expect_state("R12 wd reset released", 2'd0, 1'b1, 1'b0, 1'b0);

      // R3: V1-standby request keeps reset high
      request(1'b1, 1'b0); wait_ticks(1);
      expect_state("R3 v1 standby", 2'd2, 1'b1, 1'b0, 1'b0);

      // R6: quiet wake opens masking window
      pulse_wake(3'd0); wait_ticks(1);
      expect_state("R6 lin wake no reset", 2'd0, 1'b1, 1'b0, 1'b1);
      pulse_wd(); wait_ticks(2);
      expect_state("R6 wd masked in window", 2'd0, 1'b1, 1'b0, 1'b1);
      wait_ticks(20);
      expect_state("R6 window closed", 2'd0, 1'b1, 1'b0, 1'b0);
      pulse_wd(); wait_ticks(2);
      expect_state("R6 wd after window resets", 2'd0, 1'b0, 1'b0, 1'b0);
      wait_ticks(20);

      // R7: interrupt mode
      irq_en = 1'b1;
      request(1'b1, 1'b0); wait_ticks(1);
      pulse_wake(3'd3); wait_ticks(1);
      expect_state("R7 irq wake", 2'd0, 1'b1, 1'b1, 1'b0);
      wait_ticks(20);
      expect_state("R7 irq ends", 2'd0, 1'b1, 1'b0, 1'b0);
      irq_en = 1'b0;

      // R5: contact/open-load wake from V1-standby resets
      request(1'b1, 1'b0); wait_ticks(1);
      pulse_wake(3'd4); wait_ticks(2);
      expect_state("R5 open load wake resets", 2'd0, 1'b0, 1'b0, 1'b0);
      wait_ticks(20);
      expect_state("R5 reset released", 2'd0, 1'b1, 1'b0, 1'b0);

      // R3: both bits, battery-standby dominant
      request(1'b1, 1'b1); wait_ticks(2);
      expect_state("R3 both bits battery standby", 2'd3, 1'b0, 1'b0, 1'b0);

      // R4: wake from battery-standby
      pulse_wake(3'd1); wait_ticks(10);
      expect_state("R4 wake to active held", 2'd0, 1'b0, 1'b0, 1'b0);
      wait_ticks(10);
      expect_state("R4 released", 2'd0, 1'b1, 1'b0, 1'b0);

      // R8: Flash mode
      flash_lvl = 1'b1; wait_ticks(1);
      expect_state("R8 flash entry", 2'd1, 1'b1, 1'b0, 1'b0);
      pulse_wd(); wait_ticks(2);
      expect_state("R8 wd ignored in flash", 2'd1, 1'b1, 1'b0, 1'b0);
      flash_lvl = 1'b0; wait_ticks(2);
      expect_state("R8 flash exit resets", 2'd0, 1'b0, 1'b0, 1'b0);
      wait_ticks(20);
      expect_state("R8 flash exit released", 2'd0, 1'b1, 1'b0, 1'b0);

      // R10: thermal shutdown
      tsd = 1'b1; @(posedge clk); #1 tsd = 1'b0;
      wait_ticks(2);
      expect_state("R10 thermal to battery standby", 2'd3, 1'b0, 1'b0, 1'b0);
      pulse_wake(3'd2); wait_ticks(20);
      expect_state("R4 spi wake from battery standby", 2'd0, 1'b1, 1'b0, 1'b0);

      // R9: supply short after turn-on
      request(1'b0, 1'b1); wait_ticks(1);
      v1_good = 1'b0;
      pulse_wake(3'd0); wait_ticks(20);
      expect_state("R9 before short limit", 2'd0, 1'b0, 1'b0, 1'b0);
      wait_ticks(30);
      expect_state("R9 short to battery standby", 2'd3, 1'b0, 1'b0, 1'b0);
      v1_good = 1'b1;
      pulse_wake(3'd0); wait_ticks(20);
      expect_state("R9 recovery", 2'd0, 1'b1, 1'b0, 1'b0);

      repeat (3) @(posedge clk);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog R1: actual=timeout expected=sequence complete");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule